// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter Pair

The block holds two 16-bit counting channels that share one 8-bit mode register. Each channel either advances once per machine cycle, a fixed span of six clock periods, or counts falling edges seen on its own external pin. In the edge-counting case the pin is looked at only once per machine cycle, and an edge is recognised from two samples in a row. Each channel has a run enable, a gate option driven by a gate pin, and three counting layouts: a 13-bit count, a full 16-bit count, and an 8-bit count that reloads itself from the upper byte. Every wrap of a channel sets a sticky overflow flag.

Software uses a small byte-wide write port. Through it, it sets the mode register, preloads either byte of each count, and clears overflow flags. The counts and flags are always visible on the outputs. The machine-cycle divider is shared, so both channels advance on the same clock edge.

Top module: `mc_timer_pair`

## Requirements
- R1: After reset both counts read 0000h, both flags read 0, and the mode register holds 00h, which makes both channels 13-bit timers with gating off.
- R2: In timer mode a running channel advances by one on every sixth rising clock edge after reset is released (edges 6, 12, 18, ...), and at no other edge.
- R3: In counter mode the pin is sampled on the machine-cycle edges only. A high sample followed by a low sample at the next machine-cycle edge causes an increment at the machine-cycle edge after that. A pulse that falls between two samples has no effect.
- R4: A pin that alternates level on every machine cycle advances the count once per two machine cycles, which is 1/12 of the clock rate.
- R5: A channel advances only while its run input is 1 and either its gate bit is 0 or its gate pin is 1. A channel that is not enabled keeps its count.
- R6: Mode register layout: bits 1:0 hold the channel 0 mode (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = hold), bit 2 is the channel 0 counter select (1 = pin edges), and bit 3 is the channel 0 gate enable. Bits 7:4 hold the same fields for channel 1.
- R7: In mode 0 the count is formed from the upper byte and the low five bits of the lower byte. Bits 7:5 of the lower byte keep their value, and the flag sets when the 13-bit value wraps from all ones to zero.
- R8: In mode 1 the full 16-bit count wraps from FFFFh to 0000h and sets the flag.
- R9: In mode 2 only the lower byte counts. When it wraps from FFh, the lower byte is loaded from the upper byte, the upper byte is unchanged, and the flag sets.
- R10: In mode 3 the channel count holds its value.
- R11: An overflow flag stays set until a write to address 5 with data bit n equal to 1 clears flag n. Other flags are unaffected. A wrap on the same edge as the clear wins.
- R12: Write addresses are 0 = mode register, 1/2 = channel 0 low/high byte, 3/4 = channel 1 low/high byte, and 5 = flag clear. A byte write takes effect at the edge it is sampled on and wins over an increment on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_cnt_pin | input | 2 | External count pin per channel |
| gate_pin | input | 2 | Gate level per channel |
| run_en | input | 2 | Run enable per channel |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| cnt_val | output | 32 | Counts, channel n at bits 16n+15:16n |
| ovf_flag | output | 2 | Sticky overflow flag per channel |

## Verification
A timer increment is due on the edge that ends a machine cycle, so edges 6, 12 and so on after reset release. A pin-driven increment is due one machine cycle after the edge that took the low sample, which is two machine-cycle edges after the high sample. Writes and flag clears show after the single edge that samples them. The bench counts rising edges from reset release, drives inputs on falling edges, and reads the outputs on the falling edge right after the edge on which a result is due. Where it matters, it also reads one edge earlier to show that nothing arrived early.

// File: rtl/mct_pkg.sv
// Shared constants and types for the machine-cycle timer/counter pair.
// Assumes a byte-wide register interface and four mode bits per channel.
package mct_pkg;

    localparam int BYTE_W   = 8;          // width of each count byte and the write bus
    localparam int PRE_W    = 5;          // low-byte bits used by the 13-bit layout
    localparam int CFG_W    = 4;          // mode-register bits per channel
    localparam int CNT_W    = 2 * BYTE_W; // full count width

    // Counting layout selected by the two low bits of a channel's field.
    typedef enum logic [1:0] {
        MODE_13B    = 2'd0,
        MODE_16B    = 2'd1,
        MODE_8B_RLD = 2'd2,
        MODE_HOLD   = 2'd3
    } cnt_mode_e;

    // One channel's slice of the mode register, MSB first.
    typedef struct packed {
        logic      gate_on;
        logic      is_ctr;
        cnt_mode_e mode;
    } chan_cfg_t;

endpackage

// File: rtl/mct_cycle_div.sv
// Machine-cycle divider: produces a one-clock strobe on the last clock of
// every DIV-clock machine cycle. Assumes DIV >= 2. Phase restarts at reset.
module mct_cycle_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic mc_tick
);
    localparam int PH_W = $clog2(DIV);
    localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase_q;

    // Step the phase through 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + PH_W'(1);
    end

    // Strobe during the final phase so the next edge closes the cycle.
    always_comb mc_tick = (phase_q == LAST);

endmodule

// File: rtl/mct_pin_sampler.sv
// Samples an external count pin once per machine cycle and reports a
// high-then-low pair of consecutive samples. Assumes the pin is already
// synchronous to clk. Both sample registers reset low, so no false edge.
module mct_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic pin,
    output logic fall_seen
);
    logic samp_q;
    logic prev_q;

    // Capture the pin and shift the previous sample on machine-cycle edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else if (mc_tick) begin
            samp_q <= pin;
            prev_q <= samp_q;
        end
    end

    // An edge is pending while the older sample is high and the newer low.
    always_comb fall_seen = prev_q & ~samp_q;

endmodule

// File: rtl/mct_chan.sv
// One counting channel: low and high count bytes, layout selection, gating
// and a sticky overflow flag. Assumes mc_tick marks the machine-cycle edge
// and pin_fall is already aligned to it. Byte writes win over counting.
module mct_chan
    import mct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  chan_cfg_t         cfg,
    input  logic              run,
    input  logic              gate_lvl,
    input  logic              pin_fall,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_o
);
    localparam int SHORT_W = BYTE_W + PRE_W;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic [BYTE_W-1:0] lo_n, hi_n;
    logic              ovf_q;
    logic              wrap;
    logic              enabled;
    logic              adv;

    // Decide whether this machine-cycle edge advances the count.
    always_comb begin
        enabled = run & (~cfg.gate_on | gate_lvl);
        adv     = mc_tick & enabled & (~cfg.is_ctr | pin_fall);
    end

    // Next count value and wrap indication for the selected layout.
    always_comb begin
        lo_n = lo_q;
        hi_n = hi_q;
        wrap = 1'b0;
        case (cfg.mode)
            MODE_13B: begin
                {hi_n, lo_n[PRE_W-1:0]} = {hi_q, lo_q[PRE_W-1:0]} + SHORT_W'(1);
                wrap = &{hi_q, lo_q[PRE_W-1:0]};
            end
            MODE_16B: begin
                {hi_n, lo_n} = {hi_q, lo_q} + CNT_W'(1);
                wrap = &{hi_q, lo_q};
            end
            MODE_8B_RLD: begin
                wrap = &lo_q;
                lo_n = wrap ? hi_q : lo_q + BYTE_W'(1);
            end
            default: begin
                lo_n = lo_q;
                hi_n = hi_q;
            end
        endcase
    end

    // Count registers: advance first, then let a byte write override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (adv) begin
                lo_q <= lo_n;
                hi_q <= hi_n;
            end
            if (wr_lo) lo_q <= wr_byte;
            if (wr_hi) hi_q <= wr_byte;
        end
    end

    // Sticky flag: a wrap sets it, a clear request drops it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (adv && wrap)
            ovf_q <= 1'b1;
        else if (flag_clr)
            ovf_q <= 1'b0;
    end

    // Drive the outputs from the registers.
    always_comb begin
        cnt_o = {hi_q, lo_q};
        ovf_o = ovf_q;
    end

endmodule

// File: rtl/mc_timer_pair.sv
// Top of the timer/counter pair: the shared mode register, write-address
// decode, one machine-cycle divider and a generated sampler and channel per
// count pin. Assumes all inputs are synchronous to clk.
module mc_timer_pair
    import mct_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int MC_DIV = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        ext_cnt_pin,
    input  logic [N_CH-1:0]        gate_pin,
    input  logic [N_CH-1:0]        run_en,
    input  logic                   wr_en,
    input  logic [$clog2(2*N_CH+2)-1:0] wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [N_CH*CNT_W-1:0]  cnt_val,
    output logic [N_CH-1:0]        ovf_flag
);
    localparam int ADDR_W   = $clog2(2*N_CH+2);
    localparam int MODE_W   = N_CH * CFG_W;
    localparam logic [ADDR_W-1:0] A_MODE = '0;
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2*N_CH + 1);

    logic [MODE_W-1:0] mode_q;
    logic              mc_tick;
    logic              mode_wr;
    logic              clr_wr;

    // Decode the two shared write targets.
    always_comb begin
        mode_wr = wr_en && (wr_addr == A_MODE);
        clr_wr  = wr_en && (wr_addr == A_CLR);
    end

    // Mode register, zero after reset, loaded from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= MODE_W'(wr_data);
    end

    mct_cycle_div #(.DIV(MC_DIV)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_tick (mc_tick)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2*n + 1);
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2*n + 2);

        logic      fall;
        logic      lo_wr, hi_wr;
        chan_cfg_t cfg;

        // Per-channel decode and field slice.
        always_comb begin
            lo_wr = wr_en && (wr_addr == A_LO);
            hi_wr = wr_en && (wr_addr == A_HI);
            cfg   = chan_cfg_t'(mode_q[n*CFG_W +: CFG_W]);
        end

        mct_pin_sampler smp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .mc_tick   (mc_tick),
            .pin       (ext_cnt_pin[n]),
            .fall_seen (fall)
        );

        mct_chan ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .mc_tick  (mc_tick),
            .cfg      (cfg),
            .run      (run_en[n]),
            .gate_lvl (gate_pin[n]),
            .pin_fall (fall),
            .wr_lo    (lo_wr),
            .wr_hi    (hi_wr),
            .wr_byte  (wr_data),
            .flag_clr (clr_wr && wr_data[n]),
            .cnt_o    (cnt_val[n*CNT_W +: CNT_W]),
            .ovf_o    (ovf_flag[n])
        );
    end

endmodule

// File: rtl/mct_checker.sv
// Property checker for channel 0 of the timer/counter pair, bound to the top.
// Assumes the default address map (low byte of channel 0 at 1, clear at 5).
module mct_checker #(
    parameter int MODE_W = 8,
    parameter int CNT_TOT = 32,
    parameter int N_CH = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mc_tick,
    input logic [MODE_W-1:0]  mode_q,
    input logic               wr_en,
    input logic [2:0]         wr_addr,
    input logic [7:0]         wr_data,
    input logic [CNT_TOT-1:0] cnt_val,
    input logic [N_CH-1:0]    ovf_flag
);
    // R2: a count change without a write only follows a machine-cycle strobe.
    a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && (cnt_val[15:0] != $past(cnt_val[15:0]))) |-> $past(mc_tick));

    // R11: the flag rises only at a machine-cycle edge.
    a_r11_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag[0]) |-> $past(mc_tick));

    // R11: a set flag stays set unless a clear for bit 0 was written.
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_flag[0]) && !($past(wr_en) && ($past(wr_addr) == 3'd5) && $past(wr_data[0])))
        |-> ovf_flag[0]);

    // R10: mode 3 freezes the count when no write is made.
    a_r10_mode3_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_q[1:0]) == 2'b11) && !$past(wr_en)) |-> $stable(cnt_val[15:0]));

    // R12: a low-byte write lands exactly, whatever counting did on that edge.
    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_addr) == 3'd1)) |-> (cnt_val[7:0] == $past(wr_data)));

    // R7: in mode 0 the top three bits of the low byte never move on their own.
    a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_q[1:0]) == 2'b00) && !$past(wr_en)) |-> $stable(cnt_val[7:5]));

endmodule

bind mc_timer_pair mct_checker #(
    .MODE_W  (N_CH * mct_pkg::CFG_W),
    .CNT_TOT (N_CH * mct_pkg::CNT_W),
    .N_CH    (N_CH)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_tick  (mc_tick),
    .mode_q   (mode_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cnt_val  (cnt_val),
    .ovf_flag (ovf_flag)
);

// File: tb/mc_timer_pair_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of timer-mode cases, then directed
// tests for reset, machine-cycle spacing, pin counting, flags and writes.
module mc_timer_pair_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_cnt_pin = '0;
    logic [1:0]  gate_pin = '0;
    logic [1:0]  run_en = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] cnt_val;
    logic [1:0]  ovf_flag;

    int n_chk = 0;
    int n_err = 0;
    int pcount = 0;
    int cycles = 0;

    always #4 clk = ~clk;  // 125 MHz

    mc_timer_pair dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_cnt_pin (ext_cnt_pin),
        .gate_pin    (gate_pin),
        .run_en      (run_en),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cnt_val     (cnt_val),
        .ovf_flag    (ovf_flag)
    );

    // Rising edges since reset release; edge k sets pcount to k.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) pcount <= 0;
        else        pcount <= pcount + 1;
    end

    typedef struct packed {
        logic [7:0]  chan;
        logic [7:0]  tmod;
        logic [7:0]  th;
        logic [7:0]  tl;
        logic [7:0]  gp;
        logic [7:0]  run;
        logic [7:0]  ticks;
        logic [15:0] exp_cnt;
        logic [7:0]  exp_flag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 8'h01, 8'h00, 8'h00, 8'd0, 8'd1, 8'd5, 16'h0005, 8'd0}, // R8 plain 16-bit
        '{8'd0, 8'h01, 8'hFF, 8'hFE, 8'd0, 8'd1, 8'd3, 16'h0001, 8'd1}, // R8 wrap
        '{8'd0, 8'h00, 8'hFF, 8'hFE, 8'd0, 8'd1, 8'd3, 16'h00E1, 8'd1}, // R7 13-bit wrap
        '{8'd0, 8'h02, 8'hF0, 8'hFE, 8'd0, 8'd1, 8'd4, 16'hF0F2, 8'd1}, // R9 reload
        '{8'd1, 8'h10, 8'h12, 8'h34, 8'd0, 8'd1, 8'd2, 16'h1236, 8'd0}, // R6 channel 1
        '{8'd0, 8'h09, 8'h00, 8'h00, 8'd0, 8'd1, 8'd4, 16'h0000, 8'd0}, // R5 gated off
        '{8'd0, 8'h09, 8'h00, 8'h00, 8'd1, 8'd1, 8'd4, 16'h0004, 8'd0}, // R5 gate open
        '{8'd0, 8'h01, 8'h00, 8'h00, 8'd0, 8'd0, 8'd4, 16'h0000, 8'd0}, // R5 not running
        '{8'd0, 8'h03, 8'h00, 8'h42, 8'd0, 8'd1, 8'd4, 16'h0042, 8'd0}, // R10 hold
        '{8'd1, 8'h20, 8'h80, 8'hFF, 8'd0, 8'd1, 8'd1, 16'h8080, 8'd1}, // R9 channel 1
        '{8'd1, 8'h90, 8'h00, 8'h00, 8'd0, 8'd1, 8'd3, 16'h0000, 8'd0}  // R6 channel 1 gate
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_cnt_pin = '0; gate_pin = '0; run_en = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called on a falling edge; the write is taken by the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int n);
        while (pcount < n) @(negedge clk);
    endtask

    function automatic logic [15:0] ch_cnt(input int c);
        return cnt_val[c*16 +: 16];
    endfunction

    initial begin
        // Vector table: writes at edges 1..3, results read after edge 6*ticks.
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            int c = int'(v.chan);
            do_reset();
            run_en   = 2'(v.run[0]) << c;
            gate_pin = 2'(v.gp[0]) << c;
            wr(3'd0, v.tmod);
            wr(3'(2*c + 1), v.tl);
            wr(3'(2*c + 2), v.th);
            wait_until(6 * int'(v.ticks));
            check($sformatf("R5-R10 vec%0d count", i), ch_cnt(c), v.exp_cnt);
            check($sformatf("R11 vec%0d flag", i), 16'(ovf_flag[c]), 16'(v.exp_flag[0]));
            check($sformatf("R5 vec%0d idle channel", i), ch_cnt(1 - c), 16'h0000);
        end

        // R1: reset state, then default mode acts as an ungated 13-bit timer.
        do_reset();
        check("R1 count0", ch_cnt(0), 16'h0000);
        check("R1 count1", ch_cnt(1), 16'h0000);
        check("R1 flags", 16'(ovf_flag), 16'h0000);
        run_en = 2'b01;
        wr(3'd1, 8'h1F);
        wr(3'd2, 8'hFF);
        wait_until(6);
        check("R1 default mode wrap", ch_cnt(0), 16'h0000);
        check("R1 default mode flag", 16'(ovf_flag[0]), 16'h0001);

        // R2: one step per six edges, none early.
        do_reset();
        run_en = 2'b01;
        wr(3'd0, 8'h01);
        wait_until(5);
        check("R2 before edge 6", ch_cnt(0), 16'h0000);
        wait_until(6);
        check("R2 at edge 6", ch_cnt(0), 16'h0001);
        wait_until(11);
        check("R2 before edge 12", ch_cnt(0), 16'h0001);
        wait_until(12);
        check("R2 at edge 12", ch_cnt(0), 16'h0002);

        // R3: high sampled at edge 6, low at 12, count lands at 18.
        do_reset();
        run_en = 2'b01;
        ext_cnt_pin = 2'b01;
        wr(3'd0, 8'h05);
        wait_until(6);
        ext_cnt_pin = 2'b00;
        wait_until(12);
        check("R3 not yet at edge 12", ch_cnt(0), 16'h0000);
        wait_until(18);
        check("R3 lands at edge 18", ch_cnt(0), 16'h0001);
        // R3: short high pulse between samples is never seen.
        wait_until(20);
        ext_cnt_pin = 2'b01;
        wait_until(22);
        ext_cnt_pin = 2'b00;
        wait_until(36);
        check("R3 pulse between samples ignored", ch_cnt(0), 16'h0001);

        // R4: alternate the pin every machine cycle for ten cycles.
        do_reset();
        run_en = 2'b01;
        wr(3'd0, 8'h05);
        for (int k = 1; k <= 10; k++) begin
            wait_until(6 * (k - 1));
            ext_cnt_pin = {1'b0, k[0]};
        end
        wait_until(60);
        check("R4 one count per two cycles", ch_cnt(0), 16'h0004);

        // R11: both flags set, stay set, then clear only channel 0.
        do_reset();
        run_en = 2'b11;
        wr(3'd0, 8'h11);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        wait_until(18);
        check("R11 flags sticky", 16'(ovf_flag), 16'h0003);
        wr(3'd5, 8'h01);
        check("R11 clear only flag 0", 16'(ovf_flag), 16'h0002);

        // R12: a write on the counting edge wins, counting resumes after.
        do_reset();
        run_en = 2'b01;
        wr(3'd0, 8'h01);
        wait_until(5);
        wr(3'd1, 8'h55);
        check("R12 write beats increment", ch_cnt(0), 16'h0055);
        wait_until(12);
        check("R12 counts on from written value", ch_cnt(0), 16'h0056);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        wait (cycles >= 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule